// File: doc/BRIEF.md
# Display Data Channel Slave Status Engine

This block is the slave side of a two-wire serial link that carries display identification data. It watches the clock and data lines through synchronizers and finds start and stop conditions. It shifts in the calling byte and compares its upper seven bits against a programmable own address. When the address matches, it acknowledges and keeps the transfer direction taken from the low bit of that byte. In receive direction it acknowledges every byte and exposes the last byte to the CPU. In transmit direction it shifts bytes out of a single transmit holding register, MSB first. It samples the master's acknowledge on the ninth clock.

The CPU side is a four-entry register port: control, status, own address, and data. The data entry writes the transmit register and reads back the last received byte. A separate flag counts nothing. It marks each clock falling edge while a legacy transmit-only mode is enabled, and it drives the interrupt output when its own enable is set. The slave holds the clock low whenever a byte must go out and the CPU has not yet refilled the transmit register.

Register map. The bits named here are also used by the bench.
- Offset 0 is control. Bit0 enables the module, bit1 enables the legacy edge mode, and bit2 enables the edge interrupt.
- Offset 1 is status. Bit0 is the direction, bit1 is no-acknowledge, bit2 is the edge flag, and bit3 is transmit-empty.
- Offset 2 holds the own address in bits 6:0.
- Offset 3 writes transmit data and reads received data.

Top module: `ddc_slave_status`

## Requirements
- R1: After reset, status reads 0x0A: direction 0, no-acknowledge 1, edge flag 0, transmit-empty 1. irq_o is 0.
- R2: The slave pulls SDA low during the ninth clock of the calling byte only when bits 7:1 of that byte equal the own address at offset 2. On a mismatch it drives nothing until the next start.
- R3: Direction (status bit0) takes bit0 of a matching calling byte, where 1 means the master reads. It changes at no other time and keeps its value across a stop.
- R4: In receive direction each 8-bit byte is acknowledged on its ninth clock and can then be read at offset 3.
- R5: Transmit-empty (status bit3) clears on a CPU write to offset 3. It sets when that byte moves into the output shifter.
- R6: In transmit direction the byte written at offset 3 appears on SDA MSB first, one bit per clock.
- R7: No-acknowledge (status bit1) is cleared when SDA is low at the ninth clock of a transmitted byte and set when it is high. After a no-acknowledge the slave releases SDA.
- R8: When a byte is due and transmit-empty is 1, the slave holds SCL low until the CPU writes offset 3.
- R9: The edge flag (status bit2) sets on a falling edge of SCL only while control bits 0 and 1 are both 1.
- R10: irq_o equals the edge flag ANDed with control bit2.
- R11: The edge flag clears when status is written with bit2 = 0, and when control bit0 or bit1 becomes 0. Writing bit2 = 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A line change passes through two synchronizer flops and one edge register. The protocol engine therefore acts on it in the third clock after the change, and SDA or SCL drive follows in that same cycle. Register writes show in status one cycle later, and reads are combinational. The bench holds every bus phase for six clocks and samples on the falling clock edge at the end of each phase, so every result is settled before it is read.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX_LOAD, ST_TX, ST_TX_ACK
  } bus_state_e;

  localparam logic [1:0] OFS_CTRL   = 2'd0;
  localparam logic [1:0] OFS_STATUS = 2'd1;
  localparam logic [1:0] OFS_OWN    = 2'd2;
  localparam logic [1:0] OFS_DATA   = 2'd3;

  localparam int BIT_MOD_EN = 0;
  localparam int BIT_LEG_EN = 1;
  localparam int BIT_IRQ_EN = 2;

  localparam int BIT_DIR  = 0;
  localparam int BIT_NACK = 1;
  localparam int BIT_EDGE = 2;
  localparam int BIT_TXE  = 3;
endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[CHAIN_W-2:0], line_i};
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/ddc_bus_fsm.sv
module ddc_bus_fsm
  import ddc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_empty_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              dir_o,
  output logic              nack_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  bus_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_sh_q, tx_sh_q, rx_q;
  logic              ack_q, dir_q, nack_q;
  logic              start_det, stop_det, addr_hit;

  assign start_det = sda_fall_i & scl_i;
  assign stop_det  = sda_rise_i & scl_i;
  assign addr_hit  = (rx_sh_q[DATA_W-1 -: ADDR_W] == own_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_sh_q <= '0;
      tx_sh_q <= '1;
      rx_q    <= '0;
      ack_q   <= 1'b0;
      dir_q   <= 1'b0;
      nack_q  <= 1'b1;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      tx_sh_q <= '1;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      tx_sh_q <= '1;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      tx_sh_q <= '1;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            rx_sh_q <= {rx_sh_q[DATA_W-2:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == LAST_BIT) begin
            if (addr_hit) begin
              ack_q   <= 1'b1;
              dir_q   <= rx_sh_q[0];
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            ack_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= dir_q ? ST_TX_LOAD : ST_RX;
          end
        end
        ST_RX: begin
          if (scl_rise_i) begin
            rx_sh_q <= {rx_sh_q[DATA_W-2:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == LAST_BIT) begin
            rx_q    <= rx_sh_q;
            ack_q   <= 1'b1;
            state_q <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            ack_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_RX;
          end
        end
        ST_TX_LOAD: begin
          if (!tx_empty_i) begin
            tx_sh_q <= tx_data_i;
            cnt_q   <= '0;
            state_q <= ST_TX;
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              tx_sh_q <= '1;
              state_q <= ST_TX_ACK;
            end else begin
              tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b1};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) nack_q <= sda_i;
          else if (scl_fall_i) state_q <= nack_q ? ST_IDLE : ST_TX_LOAD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_load_o = (state_q == ST_TX_LOAD) & ~tx_empty_i & en_i & ~start_det & ~stop_det;
  assign sda_oe_o  = ack_q | ((state_q == ST_TX) & ~tx_sh_q[DATA_W-1]);
  assign scl_oe_o  = (state_q == ST_TX_LOAD);
  assign rx_data_o = rx_q;
  assign dir_o     = dir_q;
  assign nack_o    = nack_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!sda_oe_o && !scl_oe_o)); // R7
  AST_STOP_KEEPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && en_i) |=> $stable(dir_o)); // R3
  AST_HOLD_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX_LOAD && tx_empty_i) |-> scl_oe_o); // R8
  AST_NACK_ONLY_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(nack_o) |-> $past(state_q == ST_TX_ACK)); // R7
endmodule

// File: rtl/ddc_reg_file.sv
module ddc_reg_file
  import ddc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              scl_fall_i,
  input  logic              tx_load_i,
  input  logic              dir_i,
  input  logic              nack_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              mod_en_o,
  output logic [ADDR_W-1:0] own_addr_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_empty_o,
  output logic              irq_o
);
  logic [2:0]        ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] own_q;
  logic [DATA_W-1:0] tx_q;
  logic              txe_q, edge_q;
  logic              wr_ctrl, wr_stat, wr_own, wr_data, edge_on;

  assign wr_ctrl = we_i & (addr_i == OFS_CTRL);
  assign wr_stat = we_i & (addr_i == OFS_STATUS);
  assign wr_own  = we_i & (addr_i == OFS_OWN);
  assign wr_data = we_i & (addr_i == OFS_DATA);
  assign ctrl_d  = wr_ctrl ? wdata_i[2:0] : ctrl_q;
  assign edge_on = ctrl_d[BIT_MOD_EN] & ctrl_d[BIT_LEG_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      own_q  <= '0;
      tx_q   <= '0;
      txe_q  <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_own)  own_q <= wdata_i[ADDR_W-1:0];
      if (wr_data) tx_q  <= wdata_i;
      if (wr_data)        txe_q <= 1'b0;
      else if (tx_load_i) txe_q <= 1'b1;
      if (!edge_on)                          edge_q <= 1'b0;
      else if (scl_fall_i)                   edge_q <= 1'b1;
      else if (wr_stat && !wdata_i[BIT_EDGE]) edge_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: rdata_o[2:0] = ctrl_q;
      OFS_STATUS: begin
        rdata_o[BIT_DIR]  = dir_i;
        rdata_o[BIT_NACK] = nack_i;
        rdata_o[BIT_EDGE] = edge_q;
        rdata_o[BIT_TXE]  = txe_q;
      end
      OFS_OWN:  rdata_o[ADDR_W-1:0] = own_q;
      default:  rdata_o = rx_data_i;
    endcase
  end

  assign mod_en_o   = ctrl_q[BIT_MOD_EN];
  assign own_addr_o = own_q;
  assign tx_data_o  = tx_q;
  assign tx_empty_o = txe_q;
  assign irq_o      = edge_q & ctrl_q[BIT_IRQ_EN];

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_q[BIT_IRQ_EN]); // R10
  AST_EDGE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q |-> (ctrl_q[BIT_MOD_EN] && ctrl_q[BIT_LEG_EN])); // R11
  AST_TXE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> !tx_empty_o); // R5
endmodule

// File: rtl/ddc_slave_status.sv
module ddc_slave_status
  import ddc_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, lvl, rise, fall;
  logic              mod_en, tx_empty, tx_load, dir, nack;
  logic [ADDR_W-1:0] own_addr;
  logic [DATA_W-1:0] tx_data, rx_data;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    ddc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  ddc_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mod_en),
    .scl_i     (lvl[0]),
    .sda_i     (lvl[1]),
    .scl_rise_i(rise[0]),
    .scl_fall_i(fall[0]),
    .sda_rise_i(rise[1]),
    .sda_fall_i(fall[1]),
    .own_addr_i(own_addr),
    .tx_data_i (tx_data),
    .tx_empty_i(tx_empty),
    .tx_load_o (tx_load),
    .rx_data_o (rx_data),
    .dir_o     (dir),
    .nack_o    (nack),
    .sda_oe_o  (sda_oe_o),
    .scl_oe_o  (scl_oe_o)
  );

  ddc_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .scl_fall_i(fall[0]),
    .tx_load_i (tx_load),
    .dir_i     (dir),
    .nack_i    (nack),
    .rx_data_i (rx_data),
    .mod_en_o  (mod_en),
    .own_addr_o(own_addr),
    .tx_data_o (tx_data),
    .tx_empty_o(tx_empty),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/ddc_slave_status_bench.sv
module ddc_slave_status_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic scl_oe, sda_oe, irq, scl, sda;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [6:0] OWN = 7'h3A;

  always #2 clk = ~clk;
  assign scl = scl_m & ~scl_oe;
  assign sda = sda_m & ~sda_oe;

  ddc_slave_status u_ddc_slave_status (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ph();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; ph(); sda_m = 1'b0; ph(); scl_m = 1'b0; ph();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; ph(); scl_m = 1'b1; ph(); sda_m = 1'b1; ph();
  endtask

  task automatic bit_io(logic b, output logic r);
    sda_m = b; ph(); scl_m = 1'b1; ph(); r = sda; scl_m = 1'b0; ph();
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(~give_ack, r);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    logic ack, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v); chk("R1 status", v, 8'h0A);
    chk("R1 irq", {7'd0, irq}, 8'd0);

    wr(2'd0, 8'h01);
    wr(2'd2, {1'b0, OWN});

    // R2: sweep every 7-bit address, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, ack);
      chk("R2 ack", {7'd0, ack}, {7'd0, a[6:0] == OWN});
      bus_stop();
    end
    bus_start();
    send_byte({~OWN, 1'b0}, ack);
    send_byte(8'h00, ack);
    chk("R2 mismatch data ignored", {7'd0, ack}, 8'd0);
    bus_stop();

    // R4: receive bytes
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    rd(2'd1, v); chk("R3 dir write", {7'd0, v[0]}, 8'd0);
    foreach (d[i]) ;
    for (int k = 0; k < 6; k++) begin
      d = 8'(k * 8'h4B) ^ 8'hA5;
      send_byte(d, ack);
      chk("R4 rx ack", {7'd0, ack}, 8'd1);
      rd(2'd3, v); chk("R4 rx data", v, d);
    end
    bus_stop();

    // R5/R6: transmit
    wr(2'd3, 8'hC3);
    rd(2'd1, v); chk("R5 txe cleared", {7'd0, v[3]}, 8'd0);
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    chk("R2 read ack", {7'd0, ack}, 8'd1);
    rd(2'd1, v); chk("R3 dir read", {7'd0, v[0]}, 8'd1);
    chk("R5 txe after load", {7'd0, v[3]}, 8'd1);
    recv_byte(d, 1'b1);
    chk("R6 tx byte", d, 8'hC3);
    rd(2'd1, v); chk("R7 ack seen", {7'd0, v[1]}, 8'd0);

    // R8: stretch while empty
    sda_m = 1'b1; ph(); scl_m = 1'b1; ph();
    chk("R8 scl held", {7'd0, scl}, 8'd0);
    wr(2'd3, 8'h96);
    ph();
    chk("R8 scl released", {7'd0, scl}, 8'd1);
    d[7] = sda; scl_m = 1'b0; ph();
    for (int i = 6; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    chk("R6 tx byte after stretch", d, 8'h96);
    bit_io(1'b1, r);
    rd(2'd1, v); chk("R7 nack seen", {7'd0, v[1]}, 8'd1);
    chk("R7 sda released", {7'd0, sda_oe}, 8'd0);
    bus_stop();
    rd(2'd1, v); chk("R3 dir kept after stop", {7'd0, v[0]}, 8'd1);

    // R9..R11: legacy edge flag
    wr(2'd0, 8'h01);
    scl_m = 1'b0; ph(); scl_m = 1'b1; ph();
    rd(2'd1, v); chk("R9 no flag legacy off", {7'd0, v[2]}, 8'd0);
    wr(2'd0, 8'h03);
    for (int k = 0; k < 3; k++) begin
      scl_m = 1'b0; ph();
      rd(2'd1, v); chk("R9 flag on fall", {7'd0, v[2]}, 8'd1);
      chk("R10 irq masked", {7'd0, irq}, 8'd0);
      scl_m = 1'b1; ph();
      wr(2'd1, 8'h00);
      rd(2'd1, v); chk("R11 write0 clears", {7'd0, v[2]}, 8'd0);
    end
    wr(2'd0, 8'h07);
    scl_m = 1'b0; ph(); scl_m = 1'b1; ph();
    chk("R10 irq raised", {7'd0, irq}, 8'd1);
    wr(2'd1, 8'h04);
    rd(2'd1, v); chk("R11 write1 keeps", {7'd0, v[2]}, 8'd1);
    wr(2'd0, 8'h05);
    rd(2'd1, v); chk("R11 legacy off clears", {7'd0, v[2]}, 8'd0);
    chk("R10 irq low", {7'd0, irq}, 8'd0);
    wr(2'd0, 8'h07);
    scl_m = 1'b0; ph(); scl_m = 1'b1; ph();
    wr(2'd0, 8'h06);
    rd(2'd1, v); chk("R11 module off clears", {7'd0, v[2]}, 8'd0);
    scl_m = 1'b0; ph(); scl_m = 1'b1; ph();
    rd(2'd1, v); chk("R9 no flag module off", {7'd0, v[2]}, 8'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule